// File: doc/BRIEF.md
# Converter Reference and Core Power Controller

This block decides, cycle by cycle, whether the analog converter core and its internal voltage reference are powered. Every accepted command byte carries a two-bit power field. The low bit asks for the converter core to stay on. The high bit asks for the reference to be on. The serial front end reports each accepted command on `cmd_valid` with that field, and pulses `bus_boundary` whenever it sees a STOP or a repeated START on the bus.

Turning the reference off takes effect from the command itself. Turning it on is only armed by the command and is carried out at the next bus boundary. After each off-to-on transition a parameterised settling counter runs. `ref_settled` reports when conversions made against the reference may be trusted.

The converter core is also forced on from `conv_start` until `conv_done`, whatever the power field says. In the duty-cycled mode the core is therefore powered only for the span of a sample and conversion.

Top module: `refpwr_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `adc_enable`, `ref_enable` and `ref_settled` are all 0, and the stored power field is 00.
- R2: Power field bit 1 is the reference request. A command with bit 1 = 1, accepted while the reference is off, leaves `ref_enable` at 0 until a bus boundary is seen.
- R3: A bus boundary with a turn-on armed sets `ref_enable` at the next clock edge and disarms the request. A bus boundary with nothing armed changes nothing.
- R4: A command with bit 1 = 1, accepted while the reference is on, keeps `ref_enable` at 1.
- R5: A command with bit 1 = 0 clears `ref_enable` at the next edge and also cancels any armed turn-on.
- R6: `ref_settled` goes high exactly SETTLE_CYCLES cycles after `ref_enable` rises, if the reference stays on. It is 0 whenever `ref_enable` is 0, and it falls at the same edge as `ref_enable`.
- R7: Power field bit 0 is the converter request. A command with bit 0 = 1 makes `adc_enable` 1 from the next edge. That level holds until a later command clears bit 0 and no conversion is in progress.
- R8: With bit 0 = 0, `adc_enable` rises at the edge that samples `conv_start` and falls at the edge that samples `conv_done`. If both are seen in one cycle, `conv_start` wins.
- R9: A command clearing bit 0 during a conversion does not drop `adc_enable` before `conv_done`.
- R10: When a command and a bus boundary arrive in the same cycle, the command is applied first and the boundary acts on the result. A bit 1 = 1 command turns the reference on at once. A bit 1 = 0 command leaves it off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: a command byte was accepted |
| cmd_pd | input | 2 | Power field of that command (bit 1 reference, bit 0 converter) |
| bus_boundary | input | 1 | One-cycle strobe: STOP or repeated START seen |
| conv_start | input | 1 | Sampling and conversion begin |
| conv_done | input | 1 | Conversion finished |
| adc_enable | output | 1 | Converter core power enable |
| ref_enable | output | 1 | Internal reference power enable |
| ref_settled | output | 1 | Reference has been on for the full settling interval |

## Verification
Three internal states can go wrong: a lost or stale armed turn-on, a settle count that misses its terminal value, and a stale busy flag. Each of them reaches a port within one cycle of the stimulus that should have used it. A wrong armed bit shows as `ref_enable` at the wrong level on the edge after a boundary. A miscounted settle timer moves the rise of `ref_settled` away from exactly SETTLE_CYCLES cycles after `ref_enable`. A stuck busy flag holds `adc_enable` past `conv_done`. A behavioural model in the bench predicts all three outputs, and comparing them every cycle catches any of these on the first cycle where it appears.

// File: rtl/refpwr_pkg.sv
`timescale 1ns/1ps
// Shared encoding of the two-bit power field carried by each command byte.
// Assumes bit 1 requests the reference and bit 0 requests the converter core.
package refpwr_pkg;

    typedef enum logic [1:0] {
        PD_DUTY      = 2'b00,
        PD_CORE_ONLY = 2'b01,
        PD_REF_ONLY  = 2'b10,
        PD_ALL_ON    = 2'b11
    } pd_mode_e;

    function automatic logic pd_wants_ref(input pd_mode_e m);
        return m[1];
    endfunction

    function automatic logic pd_wants_core(input pd_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/ref_gate.sv
`timescale 1ns/1ps
// Reference on/off state with deferred turn-on.
// A request while off is armed and applied at the next bus boundary.
// A release applies at once and cancels any armed request.
// Assumes cmd_valid and bus_boundary are single-cycle strobes in the clk domain.
module ref_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic want_ref,
    input  logic bus_boundary,
    output logic ref_on,
    output logic turn_on,
    output logic turn_off
);
    logic on_q, armed_q;
    logic on_d, armed_d;
    logic release_req, raise_req;

    assign release_req = cmd_valid & ~want_ref;
    assign raise_req   = cmd_valid &  want_ref;

    // Next state: the command is applied first, then the bus boundary.
    always_comb begin
        on_d    = on_q;
        armed_d = armed_q;
        if (release_req) begin
            on_d    = 1'b0;
            armed_d = 1'b0;
        end else begin
            if (raise_req && !on_q)
                armed_d = 1'b1;
            if (bus_boundary) begin
                if (armed_d)
                    on_d = 1'b1;
                armed_d = 1'b0;
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q    <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            on_q    <= on_d;
            armed_q <= armed_d;
        end
    end

    assign ref_on   = on_q;
    assign turn_on  = on_d & ~on_q;
    assign turn_off = on_q & ~on_d;
endmodule

// File: rtl/settle_timer.sv
`timescale 1ns/1ps
// Counts the cycles since the reference came on and flags when it has settled.
// Assumes SETTLE_CYCLES >= 1 and that turn_on and turn_off never coincide.
module settle_timer #(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic turn_on,
    input  logic turn_off,
    input  logic active,
    output logic settled
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    // Restart on turn-on, clear on turn-off, otherwise count up to the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (turn_off || turn_on) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (active && !done_q) begin
            if (cnt_q == LAST)
                done_q <= 1'b1;
            else
                cnt_q <= cnt_q + CW'(1);
        end
    end

    assign settled = done_q;
endmodule

// File: rtl/core_power.sv
`timescale 1ns/1ps
// Converter core power: the stored converter request, or an active conversion.
// Assumes conv_start and conv_done are strobes; a start in the same cycle as a done wins.
module core_power (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic want_core,
    input  logic conv_start,
    input  logic conv_done,
    output logic adc_en
);
    logic keep_q, busy_q, en_q;
    logic keep_d, busy_d;

    // Next value of the stored converter request and of the conversion-busy flag.
    always_comb begin
        keep_d = cmd_valid ? want_core : keep_q;
        if (conv_start)
            busy_d = 1'b1;
        else if (conv_done)
            busy_d = 1'b0;
        else
            busy_d = busy_q;
    end

    // Registers; the enable output is registered so it is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_q <= 1'b0;
            busy_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            keep_q <= keep_d;
            busy_q <= busy_d;
            en_q   <= keep_d | busy_d;
        end
    end

    assign adc_en = en_q;
endmodule

// File: rtl/refpwr_ctrl.sv
`timescale 1ns/1ps
// Power controller for the converter core and the internal reference.
// Decodes the power field of accepted commands, defers reference turn-on to
// the next bus boundary and times the reference settling interval.
// Assumes all inputs are synchronous to clk and the strobes last one cycle.
module refpwr_ctrl
    import refpwr_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_pd,
    input  logic       bus_boundary,
    input  logic       conv_start,
    input  logic       conv_done,
    output logic       adc_enable,
    output logic       ref_enable,
    output logic       ref_settled
);
    pd_mode_e mode;
    logic     ref_on, ref_turn_on, ref_turn_off;

    assign mode = pd_mode_e'(cmd_pd);

    ref_gate u_ref (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .want_ref     (pd_wants_ref(mode)),
        .bus_boundary (bus_boundary),
        .ref_on       (ref_on),
        .turn_on      (ref_turn_on),
        .turn_off     (ref_turn_off)
    );

    settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .turn_on  (ref_turn_on),
        .turn_off (ref_turn_off),
        .active   (ref_on),
        .settled  (ref_settled)
    );

    core_power u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .want_core  (pd_wants_core(mode)),
        .conv_start (conv_start),
        .conv_done  (conv_done),
        .adc_en     (adc_enable)
    );

    assign ref_enable = ref_on;
endmodule

// File: rtl/refpwr_ctrl_chk.sv
`timescale 1ns/1ps
// Port-level property checker for refpwr_ctrl, attached with bind.
// Keeps its own count of the cycles the reference has been on.
module refpwr_ctrl_chk #(
    parameter int SETTLE_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_pd,
    input logic       bus_boundary,
    input logic       conv_start,
    input logic       adc_enable,
    input logic       ref_enable,
    input logic       ref_settled
);
    int on_cnt;

    // Cycles for which ref_enable has been high.
    always_ff @(posedge clk) begin
        if (!rst_n || !ref_enable)
            on_cnt <= 0;
        else
            on_cnt <= on_cnt + 1;
    end

    AST_SETTLED_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        ref_settled |-> ref_enable); // R6
    AST_SETTLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_enable) |-> !ref_settled); // R6
    AST_SETTLE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_settled) |-> on_cnt == SETTLE_CYCLES); // R6
    AST_REF_ON_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_enable) |-> $past(bus_boundary)); // R3
    AST_REF_OFF_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_enable) |-> ($past(cmd_valid) && !$past(cmd_pd[1]))); // R5
    AST_REF_KEPT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_pd[1] && ref_enable) |=> ref_enable); // R4
    AST_CORE_REQ_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_pd[0]) |=> adc_enable); // R7
    AST_CONV_POWERS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> adc_enable); // R8
endmodule

bind refpwr_ctrl refpwr_ctrl_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_pd       (cmd_pd),
    .bus_boundary (bus_boundary),
    .conv_start   (conv_start),
    .adc_enable   (adc_enable),
    .ref_enable   (ref_enable),
    .ref_settled  (ref_settled)
);

// File: tb/sim_refpwr_ctrl.sv
`timescale 1ns/1ps
module sim_refpwr_ctrl;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_pd = 2'b00;
    logic       bus_boundary = 1'b0;
    logic       conv_start = 1'b0;
    logic       conv_done = 1'b0;
    logic       adc_enable, ref_enable, ref_settled;

    int    compared = 0;
    int    mismatched = 0;
    int    cyc = 0;
    string phase = "R1";

    // Behavioural reference model state
    int m_ref = 0, m_armed = 0, m_age = 0, m_keep = 0, m_busy = 0;

    always #2.5 clk = ~clk;

    refpwr_ctrl #(.SETTLE_CYCLES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_pd(cmd_pd),
        .bus_boundary(bus_boundary), .conv_start(conv_start), .conv_done(conv_done),
        .adc_enable(adc_enable), .ref_enable(ref_enable), .ref_settled(ref_settled)
    );

    // Model: command first, then boundary; age counts edges since turn-on.
    always @(posedge clk) begin
        int was_on;
        if (!rst_n) begin
            m_ref = 0; m_armed = 0; m_age = 0; m_keep = 0; m_busy = 0;
        end else begin
            was_on = m_ref;
            if (cmd_valid) begin
                m_keep = cmd_pd[0];
                if (cmd_pd[1] == 1'b0) begin
                    m_ref = 0; m_armed = 0;
                end else if (m_ref == 0) begin
                    m_armed = 1;
                end
            end
            if (bus_boundary) begin
                if (m_armed != 0) m_ref = 1;
                m_armed = 0;
            end
            if (m_ref != 0 && was_on == 0) m_age = 0;
            else if (m_ref != 0) m_age = m_age + 1;
            else m_age = 0;
            if (conv_start) m_busy = 1;
            else if (conv_done) m_busy = 0;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            mismatched++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic cmp(input string name, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s at cycle %0d: got %0d expected %0d", phase, name, cyc, act, exp);
        end
    endtask

    // One cycle: compare outputs away from the edge, then drive the next inputs.
    task automatic step(input logic cv, input logic [1:0] pd, input logic bb,
                        input logic cs, input logic cd);
        @(negedge clk);
        cmp("adc_enable", int'(adc_enable), (m_keep != 0 || m_busy != 0) ? 1 : 0);
        cmp("ref_enable", int'(ref_enable), m_ref);
        cmp("ref_settled", int'(ref_settled), (m_ref != 0 && m_age >= N) ? 1 : 0);
        cmd_valid = cv; cmd_pd = pd; bus_boundary = bb;
        conv_start = cs; conv_done = cd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        phase = "R1";
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        idle(3);

        phase = "R8";
        step(1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
        idle(3);
        step(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        step(1'b0, 2'b00, 1'b0, 1'b1, 1'b1);
        step(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        idle(2);

        phase = "R2";
        step(1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
        idle(4);

        phase = "R3";
        step(1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
        phase = "R6";
        idle(N + 4);

        phase = "R4";
        step(1'b1, 2'b11, 1'b0, 1'b0, 1'b0);
        step(1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
        idle(3);

        phase = "R7";
        idle(2);

        phase = "R5";
        step(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
        idle(2);
        step(1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
        step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
        step(1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
        idle(3);

        phase = "R6";
        step(1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
        step(1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
        idle(3);
        step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
        idle(2);
        step(1'b1, 2'b11, 1'b0, 1'b0, 1'b0);
        step(1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
        idle(N + 2);

        phase = "R9";
        step(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
        step(1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
        step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
        idle(3);
        step(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        idle(2);

        phase = "R10";
        step(1'b1, 2'b10, 1'b1, 1'b0, 1'b0);
        idle(2);
        step(1'b1, 2'b00, 1'b1, 1'b0, 1'b0);
        idle(2);
        step(1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
        step(1'b1, 2'b00, 1'b1, 1'b0, 1'b0);
        idle(2);

        phase = "R3";
        step(1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
        idle(3);

        phase = "R1";
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule